// File: doc/BRIEF.md
# Handshake Byte Transfer Engine

This block is the device side of a three-line byte handshake with a host. The host drives two active-low control lines: a transfer-in-progress line (`tip_n`) and an acknowledge line (`tack_n`). It also chooses the shift direction (`dir_to_dev`) and owns an 8-bit shift register. The engine drives one active-low request line, `treq_n`, back to the host.

When the host sends, each change of the control pair during a transfer copies the shift-register byte into a 16-entry packet buffer. When the transfer line returns high, the engine pulses a packet-complete strobe with the byte count. When the host reads, each change of the control pair hands the next byte of a previously loaded response to the shift register. After the final byte, the request line is released.

Every handshake event schedules a single-cycle interrupt after a fixed delay. While a host packet is being collected or a response is being delivered, the engine raises a signal that blocks background device polling.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After a synchronous reset the outputs take these values: `treq_n`=1, `irq`=0, `pkt_done`=0, `poll_block`=0 and `sr_out`=0. The previous control-pair sample is set to both lines deasserted (1,1).
- R2: The engine captures a byte when `tip_n`=0, `dir_to_dev`=1 and the pair {`tip_n`,`tack_n`} differs from its value in the previous cycle. It stores `sr_in` at the next packet index. The stored byte can be read back through `pkt_rd_idx` and appears on `pkt_rd_byte` one cycle later. No byte is captured in a cycle where the pair does not change.
- R3: Once 16 bytes have been stored, further capture events are ignored. A later completion reports a length of 16, and entry 15 keeps its byte.
- R4: A load happens when `tip_n`=0, `dir_to_dev`=0, the pair changes and response bytes remain unread. The next response byte then appears on `sr_out` at the following edge. Without a load, `sr_out` holds its value.
- R5: The edge that loads the final response byte also sets `treq_n` to 1.
- R6: A sync event occurs when `tip_n` is 1 in both the current and the previous cycle and `tack_n` toggles. On a sync event `treq_n` copies the new `tack_n` level and an interrupt is scheduled.
- R7: When `tip_n` goes from 0 to 1, `pkt_done` pulses for one cycle if at least one byte was stored. `pkt_len` then holds the byte count until the next completion. The packet index returns to 0 whether or not the strobe fired. An interrupt is scheduled on this edge either way.
- R8: While `tip_n` is 1 and no sync event occurs, `treq_n` is driven to 0 whenever unread response bytes exist.
- R9: `irq` is high for exactly one cycle, `IRQ_DELAY` clock edges after the edge that registered the triggering event. A new trigger while a delay is running restarts the count.
- R10: Storing the first byte of a packet sets `poll_block`. Loading the final response byte clears it.
- R11: A pulse on `rsp_commit` sets the response length to `rsp_len`, clears the response read index and schedules an interrupt. If a load event falls in the same cycle, the commit takes priority and the load is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tip_n | input | 1 | Host transfer-in-progress, active low |
| tack_n | input | 1 | Host acknowledge, active low |
| dir_to_dev | input | 1 | 1: host shifts toward the device; 0: toward the host |
| sr_in | input | 8 | Shift-register byte supplied by the host |
| sr_out | output | 8 | Response byte handed to the shift register |
| treq_n | output | 1 | Request to the host, active low |
| irq | output | 1 | Delayed shift-register interrupt pulse |
| pkt_done | output | 1 | One-cycle packet-complete strobe |
| pkt_len | output | 5 | Byte count of the last completed packet |
| pkt_rd_idx | input | 4 | Packet buffer read index |
| pkt_rd_byte | output | 8 | Packet byte at `pkt_rd_idx`, one cycle later |
| rsp_wr_en | input | 1 | Write strobe for the response buffer |
| rsp_wr_idx | input | 4 | Response buffer write index |
| rsp_wr_byte | input | 8 | Response byte to write |
| rsp_commit | input | 1 | Start a response of `rsp_len` bytes |
| rsp_len | input | 5 | Response length, at most 16 |
| poll_block | output | 1 | High while a transfer should block polling |

## Verification
Control-line results are registered. `treq_n`, `sr_out`, `pkt_done`, `pkt_len` and `poll_block` change at the first edge that samples the new inputs. Packet read-back appears one edge after its index is driven. `irq` appears `IRQ_DELAY` edges after that first edge. The bench drives every input on the falling edge and reads the results on the next falling edge. For the interrupt it counts edges one by one and checks that the line is low at each edge except the expected one.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef logic [7:0] hsk_byte_t;

  function automatic int unsigned hsk_cw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hsk_byte_ram.sv
module hsk_byte_ram
  import hsk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = hsk_cw(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  hsk_byte_t     wdata,
  input  logic [AW-1:0] raddr,
  output hsk_byte_t     rdata
);
  hsk_byte_t mem [DEPTH];

  // read-first synchronous port, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hsk_irq_delay.sv
module hsk_irq_delay
  import hsk_pkg::*;
#(
  parameter int DELAY = 2000,
  localparam int CW = hsk_cw(DELAY)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic irq
);
  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (trig) begin
        cnt  <= CW'(DELAY - 1);
        pend <= 1'b1;
      end else if (pend) begin
        if (cnt == '0) begin
          irq  <= 1'b1;
          pend <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R9: a pulse only ends a running delay, and leaves nothing pending
  p_irq_from_pend_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend));
  p_irq_no_pend_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> !pend);
endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
  import hsk_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int IRQ_DELAY = 2000,
  localparam int AW = hsk_cw(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tip_n,
  input  logic          tack_n,
  input  logic          dir_to_dev,
  input  logic [7:0]    sr_in,
  output logic [7:0]    sr_out,
  output logic          treq_n,
  output logic          irq,
  output logic          pkt_done,
  output logic [LW-1:0] pkt_len,
  input  logic [AW-1:0] pkt_rd_idx,
  output logic [7:0]    pkt_rd_byte,
  input  logic          rsp_wr_en,
  input  logic [AW-1:0] rsp_wr_idx,
  input  logic [7:0]    rsp_wr_byte,
  input  logic          rsp_commit,
  input  logic [LW-1:0] rsp_len,
  output logic          poll_block
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic          tip_q, tack_q;
  logic [LW-1:0] out_idx, out_idx_nxt;
  logic [LW-1:0] rsp_len_q, rsp_idx, rsp_idx_nxt;
  hsk_byte_t     rsp_rd;

  logic active, pair_chg, rsp_avail;
  logic cap_evt, ld_evt, sync_evt, end_evt, trig;

  always_comb begin
    active    = !tip_n;
    pair_chg  = (tip_n != tip_q) || (tack_n != tack_q);
    rsp_avail = rsp_idx < rsp_len_q;
    cap_evt   = active && dir_to_dev && pair_chg && (out_idx < DEPTH_L);
    ld_evt    = active && !dir_to_dev && pair_chg && rsp_avail && !rsp_commit;
    sync_evt  = !active && tip_q && (tack_n != tack_q);
    end_evt   = !active && !tip_q;
    trig      = cap_evt || ld_evt || sync_evt || end_evt || rsp_commit;

    if (end_evt)      out_idx_nxt = '0;
    else if (cap_evt) out_idx_nxt = out_idx + 1'b1;
    else              out_idx_nxt = out_idx;

    if (rsp_commit)   rsp_idx_nxt = '0;
    else if (ld_evt)  rsp_idx_nxt = rsp_idx + 1'b1;
    else              rsp_idx_nxt = rsp_idx;
  end

  hsk_byte_ram #(.DEPTH(DEPTH)) u_pkt_ram (
    .clk   (clk),
    .we    (cap_evt),
    .waddr (out_idx[AW-1:0]),
    .wdata (sr_in),
    .raddr (pkt_rd_idx),
    .rdata (pkt_rd_byte)
  );

  // addressed by the next read index so the byte is ready at the event
  hsk_byte_ram #(.DEPTH(DEPTH)) u_rsp_ram (
    .clk   (clk),
    .we    (rsp_wr_en),
    .waddr (rsp_wr_idx),
    .wdata (rsp_wr_byte),
    .raddr (rsp_idx_nxt[AW-1:0]),
    .rdata (rsp_rd)
  );

  hsk_irq_delay #(.DELAY(IRQ_DELAY)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .trig (trig),
    .irq  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tip_q      <= 1'b1;
      tack_q     <= 1'b1;
      out_idx    <= '0;
      rsp_idx    <= '0;
      rsp_len_q  <= '0;
      treq_n     <= 1'b1;
      sr_out     <= '0;
      pkt_done   <= 1'b0;
      pkt_len    <= '0;
      poll_block <= 1'b0;
    end else begin
      tip_q    <= tip_n;
      tack_q   <= tack_n;
      pkt_done <= 1'b0;
      out_idx  <= out_idx_nxt;
      rsp_idx  <= rsp_idx_nxt;
      if (rsp_commit) rsp_len_q <= rsp_len;
      if (cap_evt && out_idx == '0) poll_block <= 1'b1;
      if (ld_evt) begin
        sr_out <= rsp_rd;
        if ((rsp_idx + 1'b1) >= rsp_len_q) begin
          treq_n     <= 1'b1;
          poll_block <= 1'b0;
        end
      end
      if (sync_evt) begin
        treq_n <= tack_n;
      end else if (!active) begin
        if (end_evt && out_idx != '0) begin
          pkt_done <= 1'b1;
          pkt_len  <= out_idx;
        end
        if (rsp_avail) treq_n <= 1'b0;
      end
    end
  end

  // R7: completion only on a rising transfer line, never empty
  p_done_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> ($past(tip_n) && !$past(tip_q)));
  p_done_len_r7: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (pkt_len != '0));
  // R3: packet index never passes the buffer size
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    out_idx <= DEPTH_L);
  // R10: blocking starts only while the host is sending
  p_block_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(poll_block) |-> $past(!tip_n && dir_to_dev));
  // R8: request is asserted only while the transfer line is idle
  p_treq_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(treq_n) |-> $past(tip_n));
  // R4: response byte moves only during a host read
  p_sr_move_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sr_out) |-> $past(!tip_n && !dir_to_dev));
endmodule

// File: tb/hsk_xfer_engine_tb.sv
module hsk_xfer_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;

  logic       clk = 1'b0;
  logic       rst, tip_n, tack_n, dir_to_dev, rsp_wr_en, rsp_commit;
  logic [7:0] sr_in, sr_out, pkt_rd_byte, rsp_wr_byte;
  logic       treq_n, irq, pkt_done, poll_block;
  logic [4:0] pkt_len, rsp_len;
  logic [3:0] pkt_rd_idx, rsp_wr_idx;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsk_xfer_engine #(.DEPTH(16), .IRQ_DELAY(DLY)) dut_i (
    .clk(clk), .rst(rst), .tip_n(tip_n), .tack_n(tack_n),
    .dir_to_dev(dir_to_dev), .sr_in(sr_in), .sr_out(sr_out),
    .treq_n(treq_n), .irq(irq), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .pkt_rd_idx(pkt_rd_idx), .pkt_rd_byte(pkt_rd_byte),
    .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx),
    .rsp_wr_byte(rsp_wr_byte), .rsp_commit(rsp_commit),
    .rsp_len(rsp_len), .poll_block(poll_block)
  );

  typedef struct packed {
    logic tip, tack, dir, commit;
    logic [7:0] sr;
    logic treq;
    logic [7:0] sro;
    logic done;
    logic [4:0] len;
    logic blk;
  } vec_t;

  // send 3 bytes, commit a 3-byte response (A0..A2), read it, then idle sync
  localparam logic [27:0] TBL [17] = '{
    {4'b1110, 8'h00, 1'b1, 8'h00, 1'b0, 5'd0, 1'b0},
    {4'b0110, 8'h11, 1'b1, 8'h00, 1'b0, 5'd0, 1'b1},
    {4'b0010, 8'h22, 1'b1, 8'h00, 1'b0, 5'd0, 1'b1},
    {4'b0010, 8'h44, 1'b1, 8'h00, 1'b0, 5'd0, 1'b1},
    {4'b0110, 8'h33, 1'b1, 8'h00, 1'b0, 5'd0, 1'b1},
    {4'b1110, 8'h00, 1'b1, 8'h00, 1'b1, 5'd3, 1'b1},
    {4'b1101, 8'h00, 1'b1, 8'h00, 1'b0, 5'd3, 1'b1},
    {4'b1100, 8'h00, 1'b0, 8'h00, 1'b0, 5'd3, 1'b1},
    {4'b0100, 8'h00, 1'b0, 8'hA0, 1'b0, 5'd3, 1'b1},
    {4'b0000, 8'h00, 1'b0, 8'hA1, 1'b0, 5'd3, 1'b1},
    {4'b0100, 8'h00, 1'b1, 8'hA2, 1'b0, 5'd3, 1'b0},
    {4'b0000, 8'h00, 1'b1, 8'hA2, 1'b0, 5'd3, 1'b0},
    {4'b1000, 8'h00, 1'b1, 8'hA2, 1'b0, 5'd3, 1'b0},
    {4'b1100, 8'h00, 1'b1, 8'hA2, 1'b0, 5'd3, 1'b0},
    {4'b1000, 8'h00, 1'b0, 8'hA2, 1'b0, 5'd3, 1'b0},
    {4'b1000, 8'h00, 1'b0, 8'hA2, 1'b0, 5'd3, 1'b0},
    {4'b1100, 8'h00, 1'b1, 8'hA2, 1'b0, 5'd3, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tip_n = 1'b1; tack_n = 1'b1; dir_to_dev = 1'b1;
    sr_in = '0; rsp_wr_en = 1'b0; rsp_wr_idx = '0; rsp_wr_byte = '0;
    rsp_commit = 1'b0; rsp_len = '0; pkt_rd_idx = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr_rsp(input logic [3:0] idx, input logic [7:0] b);
    rsp_wr_en = 1'b1; rsp_wr_idx = idx; rsp_wr_byte = b;
    step();
    rsp_wr_en = 1'b0;
  endtask

  task automatic rd_pkt(input string tag, input logic [3:0] idx, input logic [7:0] exp);
    pkt_rd_idx = idx;
    step();
    chk(tag, pkt_rd_byte, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 treq_n", treq_n, 1); chk("R1 irq", irq, 0);
    chk("R1 pkt_done", pkt_done, 0); chk("R1 poll_block", poll_block, 0);
    chk("R1 sr_out", sr_out, 0);

    // table walk: R2 R4 R5 R6 R7 R8 R10 R11
    wr_rsp(4'd0, 8'hA0); wr_rsp(4'd1, 8'hA1); wr_rsp(4'd2, 8'hA2);
    rsp_len = 5'd3;
    for (int i = 0; i < 17; i++) begin
      vec_t v;
      v = vec_t'(TBL[i]);
      tip_n = v.tip; tack_n = v.tack; dir_to_dev = v.dir;
      rsp_commit = v.commit; sr_in = v.sr;
      step();
      chk($sformatf("R8 R6 R5 treq_n row %0d", i), treq_n, v.treq);
      chk($sformatf("R4 sr_out row %0d", i), sr_out, v.sro);
      chk($sformatf("R7 pkt_done row %0d", i), pkt_done, v.done);
      chk($sformatf("R7 R2 pkt_len row %0d", i), pkt_len, v.len);
      chk($sformatf("R10 poll_block row %0d", i), poll_block, v.blk);
    end
    rsp_commit = 1'b0;
    rd_pkt("R2 byte0", 4'd0, 8'h11);
    rd_pkt("R2 byte1", 4'd1, 8'h22);
    rd_pkt("R2 byte2", 4'd2, 8'h33);

    // R3 overflow: 18 capture events, only 16 kept
    do_reset();
    dir_to_dev = 1'b1; sr_in = 8'h40; tip_n = 1'b0;
    step();
    for (int i = 1; i < 18; i++) begin
      sr_in = 8'h40 + 8'(i); tack_n = ~tack_n;
      step();
    end
    tip_n = 1'b1;
    step();
    chk("R3 pkt_done", pkt_done, 1);
    chk("R3 pkt_len", pkt_len, 16);
    rd_pkt("R3 last entry", 4'd15, 8'h4F);

    // R7 empty completion: no strobe, interrupt still scheduled
    tip_n = 1'b0; dir_to_dev = 1'b0;
    step();
    tip_n = 1'b1;
    step();
    chk("R7 empty no strobe", pkt_done, 0);
    for (int k = 1; k <= DLY; k++) begin
      step();
      chk($sformatf("R7 irq edge %0d", k), irq, (k == DLY));
    end

    // R9 timing and single pulse
    do_reset();
    tack_n = 1'b0;
    step();
    chk("R9 irq edge 0", irq, 0);
    for (int k = 1; k <= DLY + 1; k++) begin
      step();
      chk($sformatf("R9 irq edge %0d", k), irq, (k == DLY));
    end
    // R9 restart
    tack_n = 1'b1;
    step();
    step();
    tack_n = 1'b0;
    step();
    for (int k = 3; k <= DLY + 3; k++) begin
      step();
      chk($sformatf("R9 restart edge %0d", k), irq, (k == DLY + 2));
    end

    // R11 commit schedules irq and wins over a same-cycle load
    do_reset();
    wr_rsp(4'd0, 8'hB0); wr_rsp(4'd1, 8'hB1);
    rsp_len = 5'd1; rsp_commit = 1'b1;
    step();
    rsp_commit = 1'b0;
    for (int k = 1; k <= DLY; k++) begin
      step();
      chk($sformatf("R11 irq edge %0d", k), irq, (k == DLY));
    end
    chk("R11 R8 treq pending", treq_n, 0);
    dir_to_dev = 1'b0; tip_n = 1'b0; rsp_len = 5'd2; rsp_commit = 1'b1;
    step();
    rsp_commit = 1'b0;
    chk("R11 load suppressed", sr_out, 8'h00);
    tack_n = 1'b0;
    step();
    chk("R11 first byte", sr_out, 8'hB0);
    chk("R11 treq still low", treq_n, 0);
    tack_n = 1'b1;
    step();
    chk("R11 R5 second byte", sr_out, 8'hB1);
    chk("R5 treq released", treq_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule